// File: doc/BRIEF.md
# Machine Trap Cause Register

This block holds the cause of the most recent trap taken into machine mode. The word is one interrupt flag in the most significant bit and a cause code in all the lower bits. The data path is 32 or 64 bits wide, chosen by a parameter. Hardware loads the register whenever the core takes a trap. Machine-mode software can also write it through a CSR access port.

A software write is stored only if the flag and code together form a defined cause. Interrupt causes and exception causes are checked against separate tables of legal codes. A build parameter sets what happens when a write is undefined. In one mode the block pulses an illegal-instruction indication and keeps its contents. In the other mode it keeps its contents and reports nothing. The read port always shows the current contents.

Top module: `trap_cause_csr`

## Requirements
- R1: After reset is released, csr_rdata reads all zeros (flag 0, code 0) and bad_write is 0.
- R2: When trap_take is 1 at a clock edge, the register loads trap_is_irq into bit XLEN-1 and trap_code into bits XLEN-2:0.
- R3: With the flag (bit XLEN-1) set, a written code is legal only if it is 1, 2, 3, 5, 6, 7, 9, 10, 11 or 12.
- R4: With the flag clear, a written code is legal only if it is 0 to 13, 15, 18 or 20 to 23. Codes 14, 16, 17, 19 and any value of 24 or above are undefined.
- R5: A legal software write stores csr_wdata exactly as given.
- R6: A software write with an undefined flag/code pair changes neither the flag nor the code.
- R7: With TRAP_ON_BAD=1, an undefined software write drives bad_write to 1 for exactly the one cycle after the write edge. With TRAP_ON_BAD=0, bad_write is always 0.
- R8: When trap_take and a software write fall on the same edge, the trap values are stored and the write is dropped.
- R9: A software write takes effect only when csr_addr is 12'h342 and csr_priv_m is 1. Any other write leaves the register unchanged and raises no bad_write.
- R10: csr_rdata shows the value held before any write in the current cycle. An updated value appears only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_take | input | 1 | A trap into machine mode is being taken |
| trap_is_irq | input | 1 | The trap being taken is an asynchronous interrupt |
| trap_code | input | XLEN-1 | Cause code of the trap being taken |
| csr_wr_en | input | 1 | Software CSR write request |
| csr_addr | input | 12 | CSR address of the write |
| csr_priv_m | input | 1 | The access comes from machine privilege |
| csr_wdata | input | XLEN | Value software writes |
| csr_rdata | output | XLEN | Current register contents |
| bad_write | output | 1 | One-cycle pulse after an undefined software write (trap mode only) |

## Verification
The bench targets codes next to the legality boundaries. These are interrupt codes 0, 4, 8 and 13, exception codes 14, 16, 17, 19 and 24, and nonzero code bits above bit 4. A table built with one entry off would store a cause that should be refused, or refuse one that is legal. It also drives a trap and a write on the same edge, where a wrong priority would leave the software value in place of the trap cause. Writes to the wrong address or from a lower privilege are sent as well; a weak address decode would let them change the register. A second instance is built in hold mode, and it must never raise bad_write.

// File: rtl/trap_cause_pkg.sv
// Shared constants and helpers for the trap cause register.
// Assumes code values of interest fit in five bits; higher code bits must be zero.
package trap_cause_pkg;
    localparam logic [11:0] CAUSE_CSR_ADDR = 12'h342;
    // Bit n set means code n is a defined interrupt cause.
    localparam logic [31:0] IRQ_LEGAL_MASK = 32'h0000_1EEE;
    // Bit n set means code n is a defined exception cause.
    localparam logic [31:0] EXC_LEGAL_MASK = 32'h00F4_BFFF;
endpackage

// File: rtl/cause_legal_chk.sv
// Decides whether a flag/code pair is a defined trap cause.
// Assumes CW >= 6; pure combinational.
module cause_legal_chk
    import trap_cause_pkg::*;
#(
    parameter int CW = 63
) (
    input  logic          is_irq,
    input  logic [CW-1:0] code,
    output logic          legal
);
    localparam int LOW_BITS = 5;

    logic       high_clear;
    logic [4:0] idx;

    // Any code bit above the table index makes the cause undefined.
    always_comb begin
        high_clear = (code[CW-1:LOW_BITS] == '0);
        idx        = code[LOW_BITS-1:0];
    end

    // Pick the table that belongs to the flag and look the code up.
    always_comb begin
        if (is_irq) legal = high_clear & IRQ_LEGAL_MASK[idx];
        else        legal = high_clear & EXC_LEGAL_MASK[idx];
    end
endmodule

// File: rtl/cause_store.sv
// Storage for the flag and code, with the trap load ahead of the software load.
// Assumes sw_load is only asserted for already legalized data.
module cause_store #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_load,
    input  logic [XLEN-1:0] hw_data,
    input  logic            sw_load,
    input  logic [XLEN-1:0] sw_data,
    output logic [XLEN-1:0] q
);
    // Update the register; the trap capture has priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (hw_load) q <= hw_data;
        else if (sw_load) q <= sw_data;
    end
endmodule

// File: rtl/bad_write_flag.sv
// Produces the one-cycle illegal-write pulse, or ties it low in hold mode.
// Assumes rejected is high for a single cycle per undefined write.
module bad_write_flag #(
    parameter bit TRAP_ON_BAD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rejected,
    output logic pulse
);
    generate
        if (TRAP_ON_BAD) begin : g_trap
            // Register the rejection so the pulse lasts one full cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse <= 1'b0;
                else        pulse <= rejected;
            end
        end else begin : g_hold
            logic unused_rej;
            // Hold mode never reports an undefined write.
            always_comb begin
                unused_rej = rejected & clk & rst_n;
                pulse      = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/trap_cause_csr.sv
// Machine trap cause register: trap capture plus legalized software writes.
// Assumes writes arrive one per cycle and that the read needs no address decode.
module trap_cause_csr
    import trap_cause_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter bit TRAP_ON_BAD = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_take,
    input  logic            trap_is_irq,
    input  logic [XLEN-2:0] trap_code,
    input  logic            csr_wr_en,
    input  logic [11:0]     csr_addr,
    input  logic            csr_priv_m,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            bad_write
);
    localparam int CW = XLEN - 1;

    logic wr_hit;
    logic wr_legal;
    logic sw_load;
    logic rejected;

    // Decode a software write aimed at this register from machine mode.
    always_comb begin
        wr_hit   = csr_wr_en & csr_priv_m & (csr_addr == CAUSE_CSR_ADDR);
        sw_load  = wr_hit & wr_legal;
        rejected = wr_hit & ~wr_legal;
    end

    cause_legal_chk #(.CW(CW)) u_legal (
        .is_irq (csr_wdata[XLEN-1]),
        .code   (csr_wdata[CW-1:0]),
        .legal  (wr_legal)
    );

    cause_store #(.XLEN(XLEN)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_load (trap_take),
        .hw_data ({trap_is_irq, trap_code}),
        .sw_load (sw_load),
        .sw_data (csr_wdata),
        .q       (csr_rdata)
    );

    bad_write_flag #(.TRAP_ON_BAD(TRAP_ON_BAD)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rejected (rejected),
        .pulse    (bad_write)
    );
endmodule

// File: rtl/trap_cause_csr_chk.sv
// Checker for trap_cause_csr, attached by bind. Watches ports only.
module trap_cause_csr_chk
    import trap_cause_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter bit TRAP_ON_BAD = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_take,
    input logic            trap_is_irq,
    input logic [XLEN-2:0] trap_code,
    input logic            csr_wr_en,
    input logic [11:0]     csr_addr,
    input logic            csr_priv_m,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] csr_rdata,
    input logic            bad_write
);
    logic hit;
    logic ok;
    logic past_valid;

    // Track whether a clock edge has passed since reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    // Independent legality view for the checks.
    always_comb begin
        hit = csr_wr_en && csr_priv_m && csr_addr == CAUSE_CSR_ADDR;
        if (csr_wdata[XLEN-2:5] != '0) ok = 1'b0;
        else if (csr_wdata[XLEN-1])    ok = IRQ_LEGAL_MASK[csr_wdata[4:0]];
        else                           ok = EXC_LEGAL_MASK[csr_wdata[4:0]];
    end

    // R2 R8
    trap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> csr_rdata == {$past(trap_is_irq), $past(trap_code)});
    // R5
    legal_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && hit && ok) |=> csr_rdata == $past(csr_wdata));
    // R6 R9
    no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_take && !(hit && ok)) |=> $stable(csr_rdata));
    // R7
    bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> bad_write == (TRAP_ON_BAD && $past(hit && !ok)));
    // R1
    reset_val_chk: assert property (@(posedge clk)
        $past(!rst_n) && past_valid == 1'b0 |-> csr_rdata == '0 && !bad_write);
endmodule

bind trap_cause_csr trap_cause_csr_chk #(.XLEN(XLEN), .TRAP_ON_BAD(TRAP_ON_BAD)) u_chk (.*);

// File: tb/tb_trap_cause_csr.sv
// Self-checking bench: random and directed writes and traps against a bench model.
module tb_trap_cause_csr;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_take = 1'b0;
    logic            trap_is_irq = 1'b0;
    logic [XLEN-2:0] trap_code = '0;
    logic            csr_wr_en = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic            csr_priv_m = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] rdata_t, rdata_h;
    logic            bad_t, bad_h;

    int unsigned n_vec = 0;
    int unsigned n_err = 0;
    logic [XLEN-1:0] model = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trap_cause_csr #(.XLEN(XLEN), .TRAP_ON_BAD(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
        .csr_priv_m(csr_priv_m), .csr_wdata(csr_wdata), .csr_rdata(rdata_t),
        .bad_write(bad_t));

    trap_cause_csr #(.XLEN(XLEN), .TRAP_ON_BAD(1'b0)) dut_hold (
        .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
        .csr_priv_m(csr_priv_m), .csr_wdata(csr_wdata), .csr_rdata(rdata_h),
        .bad_write(bad_h));

    // Legal cause list written from the requirements (R3, R4).
    function automatic bit is_legal(input logic [XLEN-1:0] v);
        logic [XLEN-2:0] c;
        c = v[XLEN-2:0];
        if (v[XLEN-1]) begin
            case (c)
                1, 2, 3, 5, 6, 7, 9, 10, 11, 12: return 1'b1;
                default: return 1'b0;
            endcase
        end
        if (c <= 13) return 1'b1;
        case (c)
            15, 18, 20, 21, 22, 23: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check old read (R10), then check result after the edge.
    task automatic step(input bit tt, input bit ti, input logic [XLEN-2:0] tc,
                        input bit we, input logic [11:0] ad, input bit pm,
                        input logic [XLEN-1:0] wd, input string req);
        bit hit;
        bit exp_bad;
        trap_take = tt; trap_is_irq = ti; trap_code = tc;
        csr_wr_en = we; csr_addr = ad; csr_priv_m = pm; csr_wdata = wd;
        hit = we && pm && ad == 12'h342;
        exp_bad = hit && !is_legal(wd);
        #1;
        check({req, " R10 pre-edge read"}, rdata_t, model);
        if (tt) model = {ti, tc};
        else if (hit && is_legal(wd)) model = wd;
        @(negedge clk);
        check(req, rdata_t, model);
        check({req, " hold"}, rdata_h, model);
        check({req, " R7 pulse"}, {63'd0, bad_t}, {63'd0, exp_bad});
        check({req, " R7 hold quiet"}, {63'd0, bad_h}, '0);
    endtask

    task automatic idle();
        step(0, 0, '0, 0, 12'h342, 1, '0, "idle");
        check("R7 one cycle", {63'd0, bad_t}, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", rdata_t, '0);
        check("R1 reset pulse", {63'd0, bad_t}, '0);

        // R5 legal writes, R3/R4 boundaries
        step(0, 0, '0, 1, 12'h342, 1, {1'b1, 63'd11}, "R5 legal irq 11");
        step(0, 0, '0, 1, 12'h342, 1, {1'b0, 63'd23}, "R4 legal exc 23");
        step(0, 0, '0, 1, 12'h342, 1, {1'b1, 63'd12}, "R3 legal irq 12");
        foreach (int_codes_dummy[i]) ;
        for (int c = 0; c < 26; c++) begin
            step(0, 0, '0, 1, 12'h342, 1, {1'b1, 63'(c)}, "R3 irq sweep");
            step(0, 0, '0, 1, 12'h342, 1, {1'b0, 63'(c)}, "R4 exc sweep");
        end
        // R6 high code bits make the cause undefined
        step(0, 0, '0, 1, 12'h342, 1, {1'b0, 63'd1} | (64'd1 << 40), "R6 high bit");
        idle();
        step(0, 0, '0, 1, 12'h342, 1, {1'b1, 63'd13}, "R6 irq 13");
        idle();
        // R8 trap beats write
        step(1, 0, 63'd7, 1, 12'h342, 1, {1'b1, 63'd3}, "R8 same edge");
        step(1, 1, 63'd9, 1, 12'h342, 1, {1'b0, 63'd14}, "R8 trap with bad write");
        // R9 wrong address, wrong privilege
        step(0, 0, '0, 1, 12'h343, 1, {1'b0, 63'd2}, "R9 wrong address");
        step(0, 0, '0, 1, 12'h342, 0, {1'b0, 63'd2}, "R9 not machine");
        // R2 trap capture with any code
        step(1, 1, 63'h7FFF_0000_0000_1234, 0, '0, 0, '0, "R2 trap wide code");

        // Constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [XLEN-1:0] wd;
            logic [11:0] ad;
            wd = {$urandom() % 2 == 0, 58'd0, 5'($urandom())};
            if ($urandom() % 16 == 0) wd[XLEN-2:5] = {$urandom(), $urandom()};
            ad = ($urandom() % 8 == 0) ? 12'($urandom()) : 12'h342;
            step($urandom() % 6 == 0, $urandom() % 2 == 1, 63'($urandom()),
                 $urandom() % 4 != 0, ad, $urandom() % 8 != 0, wd, "R5 R6 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    int int_codes_dummy[1];
endmodule